// File: doc/BRIEF.md
# InfoFrame Packet Assembler

This block turns register-held video-format and audio-format fields into the two auxiliary description packets that a digital display link sends alongside each frame: the video-format packet and the audio-format packet. It forms a three-byte header for each packet and computes a one-byte checksum over the header and the body. It also lays the checksum and body out in 32-bit words for a packet memory. On a frame-start strobe it sends the bytes of every armed packet through a valid/ready byte interface.

Each packet has two controls. A one-cycle arm pulse sets that packet's pending flag. A repeat level keeps the flag set once the packet has been sent. Without repeat, the flag clears itself after one full transmission. With repeat, the packet goes out on every frame. At a frame start the block copies all payload inputs into shadow registers. The stream and the packed words come only from that copy, so a change to the inputs made in the middle of a packet takes effect at the next frame start.

Top module: `ifr_pkt_asm`

## Requirements
- R1: The video packet is streamed as type byte 0x82, version 0x02, length 13 (0x0D), then the checksum, then data bytes DB1 to DB13, where DB1 is `avi_db_i[7:0]` and DBk is `avi_db_i[8k-1:8k-8]`. `last_o` marks the final byte.
- R2: In each packet the checksum equals 256 minus the low 8 bits of the sum of the three header bytes and all body bytes, so that header, checksum and body add to 0 modulo 256.
- R3: `avi_words_o` holds the video packet as four 32-bit words, filled from the least significant byte upward. Word 0 (bits 31:0) is {DB3, DB2, DB1, checksum}. Word 1 is {DB7, DB6, DB5, DB4}. Word 2 is {DB11, DB10, DB9, DB8}. Word 3 (bits 127:96) is {0x02, 0x00, DB13, DB12}.
- R4: `aud_words_o` bits 7:0 hold the audio checksum and bits 10:8 the channel count. Bits 39:32 hold the channel allocation, bits 46:43 the level shift and bit 47 the down-mix inhibit flag. All other bits are zero.
- R5: The audio packet is streamed as 0x84, 0x01, 0x0A, then the checksum, then ten body bytes. Body byte 1 is the channel count, zero-extended. Byte 4 is the channel allocation. Byte 5 is (level shift << 3) | (down-mix inhibit << 7). All other body bytes are zero.
- R6: When both packets are pending at a frame start, the whole video packet is sent first and the audio packet follows it directly.
- R7: An arm pulse sets the pending flag, which shows on `avi_pend_o` or `aud_pend_o`. No byte is sent until a frame start finds at least one pending flag set. `valid_o` rises only in the cycle after such a frame start.
- R8: When the repeat input is low at the final accepted byte of a packet, that packet's pending flag clears, and later frame starts send nothing for it. When the repeat input is high, the flag stays set and the packet is sent again at every frame start.
- R9: Payload inputs are sampled only at the frame start that begins a transmission. Changes made afterwards leave both the stream and the packed words unchanged until the next frame start.
- R10: While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `byte_o` holds its value.
- R11: A frame start that arrives while a transmission is in progress is ignored. It neither restarts nor extends the current sequence.
- R12: After reset `valid_o`, `avi_pend_o` and `aud_pend_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | One-cycle frame-start strobe |
| avi_db_i | input | 104 | Video data bytes DB1 (bits 7:0) to DB13 |
| aud_cc_i | input | 3 | Audio channel count code |
| aud_ca_i | input | 8 | Audio channel allocation |
| aud_lsv_i | input | 4 | Audio level-shift value |
| aud_dmi_i | input | 1 | Audio down-mix inhibit |
| avi_send_i | input | 1 | Arm pulse for the video packet |
| avi_cont_i | input | 1 | Repeat the video packet on every frame |
| aud_send_i | input | 1 | Arm pulse for the audio packet |
| aud_cont_i | input | 1 | Repeat the audio packet on every frame |
| ready_i | input | 1 | Downstream accepts the byte |
| byte_o | output | 8 | Stream byte |
| valid_o | output | 1 | Stream byte valid |
| last_o | output | 1 | Last byte of the current packet |
| aud_sel_o | output | 1 | High while the audio packet is streaming |
| avi_pend_o | output | 1 | Video packet pending |
| aud_pend_o | output | 1 | Audio packet pending |
| avi_words_o | output | 128 | Packed video packet words from the latest snapshot |
| aud_words_o | output | 64 | Packed audio packet words from the latest snapshot |

## Verification
The bench checks the checksum with payloads whose sums wrap past 256 and with an all-zero audio body. A checksum that leaves out the header bytes, or that fails to wrap, gives a byte that does not match. It then arms both packets with repeat set, changes every payload input in the middle of the video packet and strobes a frame start during the same packet. A design that reads live inputs would mix old and new bytes. A design that accepts the extra strobe would restart and send more than 31 bytes. Further tests cover a one-shot packet that must not go out a second time, packets that must stay armed under repeat, and a ready signal that pauses the stream often enough to catch a byte changing or a byte lost under backpressure.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
   localparam logic [7:0] AVI_TYPE = 8'h82;
   localparam logic [7:0] AVI_VER  = 8'h02;
   localparam logic [7:0] AUD_TYPE = 8'h84;
   localparam logic [7:0] AUD_VER  = 8'h01;
   localparam int HDR_NB = 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_AVI  = 2'd1,
      ST_AUD  = 2'd2
   } ifr_state_e;
endpackage

// File: rtl/ifr_cksum.sv
module ifr_cksum #(
   parameter int NB = 16
) (
   input  logic [NB*8-1:0] bytes_i,
   output logic [7:0]      cks_o
);
   if (NB < 1) begin : g_bad_nb
      $error("ifr_cksum: NB must be at least 1");
   end

   logic [7:0] acc;
   always_comb begin
      acc = 8'h00;
      for (int i = 0; i < NB; i++) acc = acc + bytes_i[i*8 +: 8];
      cks_o = 8'h00 - acc;
   end
endmodule

// File: rtl/ifr_seq.sv
module ifr_seq
   import ifr_pkg::*;
#(
   parameter int AVI_TOT = 17,
   parameter int AUD_TOT = 14,
   parameter int IDX_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start_i,
   input  logic             avi_set_i,
   input  logic             avi_cont_i,
   input  logic             aud_set_i,
   input  logic             aud_cont_i,
   input  logic             ready_i,
   output logic             snap_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             aud_sel_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             avi_pend_o,
   output logic             aud_pend_o
);
   localparam logic [IDX_W-1:0] AVI_LAST = IDX_W'(AVI_TOT - 1);
   localparam logic [IDX_W-1:0] AUD_LAST = IDX_W'(AUD_TOT - 1);

   if ((1 << IDX_W) < AVI_TOT || (1 << IDX_W) < AUD_TOT) begin : g_bad_idx
      $error("ifr_seq: IDX_W too narrow for packet length");
   end

   ifr_state_e st_q;
   logic       go_aud_q;
   logic       beat;
   logic       avi_done, aud_done;

   assign valid_o   = (st_q != ST_IDLE);
   assign aud_sel_o = (st_q == ST_AUD);
   assign last_o    = (st_q == ST_AVI) ? (idx_o == AVI_LAST)
                    : (st_q == ST_AUD) ? (idx_o == AUD_LAST) : 1'b0;
   assign beat      = valid_o && ready_i;
   assign snap_o    = (st_q == ST_IDLE) && frame_start_i && (avi_pend_o || aud_pend_o);
   assign avi_done  = (st_q == ST_AVI) && beat && last_o;
   assign aud_done  = (st_q == ST_AUD) && beat && last_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         idx_o    <= '0;
         go_aud_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (snap_o) begin
               st_q     <= avi_pend_o ? ST_AVI : ST_AUD;
               go_aud_q <= aud_pend_o;
               idx_o    <= '0;
            end
            ST_AVI: if (beat) begin
               if (last_o) begin
                  idx_o <= '0;
                  st_q  <= go_aud_q ? ST_AUD : ST_IDLE;
               end else idx_o <= idx_o + 1'b1;
            end
            ST_AUD: if (beat) begin
               if (last_o) begin
                  idx_o <= '0;
                  st_q  <= ST_IDLE;
               end else idx_o <= idx_o + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avi_pend_o <= 1'b0;
         aud_pend_o <= 1'b0;
      end else begin
         if (avi_set_i) avi_pend_o <= 1'b1;
         else if (avi_done && !avi_cont_i) avi_pend_o <= 1'b0;
         if (aud_set_i) aud_pend_o <= 1'b1;
         else if (aud_done && !aud_cont_i) aud_pend_o <= 1'b0;
      end
   end

   // R7: the stream starts only right after an accepted frame start
   p_start_after_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(frame_start_i));

   // R8: one-shot packet disarms after its final beat
   p_oneshot_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (avi_done && !avi_cont_i && !avi_set_i) |=> !avi_pend_o);

   // R8: repeat keeps the packet armed
   p_repeat_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (aud_done && aud_cont_i) |=> aud_pend_o);

   // R6: audio never precedes video within a frame
   p_avi_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) == ST_AUD) |-> (st_q != ST_AVI));
endmodule

// File: rtl/ifr_pkt_asm.sv
module ifr_pkt_asm
   import ifr_pkg::*;
#(
   parameter int AVI_NB = 13,
   parameter int AUD_NB = 10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          frame_start_i,
   input  logic [AVI_NB*8-1:0]           avi_db_i,
   input  logic [2:0]                    aud_cc_i,
   input  logic [7:0]                    aud_ca_i,
   input  logic [3:0]                    aud_lsv_i,
   input  logic                          aud_dmi_i,
   input  logic                          avi_send_i,
   input  logic                          avi_cont_i,
   input  logic                          aud_send_i,
   input  logic                          aud_cont_i,
   input  logic                          ready_i,
   output logic [7:0]                    byte_o,
   output logic                          valid_o,
   output logic                          last_o,
   output logic                          aud_sel_o,
   output logic                          avi_pend_o,
   output logic                          aud_pend_o,
   output logic [((AVI_NB+5)/4)*32-1:0]  avi_words_o,
   output logic [63:0]                   aud_words_o
);
   localparam int AVI_TOT = AVI_NB + HDR_NB + 1;
   localparam int AUD_TOT = AUD_NB + HDR_NB + 1;
   localparam int MAX_TOT = (AVI_TOT > AUD_TOT) ? AVI_TOT : AUD_TOT;
   localparam int IDX_W   = $clog2(MAX_TOT);
   localparam int AVI_NW  = (AVI_NB + 5) / 4;

   if (AVI_NB < 1 || AVI_NB > 255) begin : g_bad_avi
      $error("ifr_pkt_asm: AVI_NB out of range");
   end
   if (AUD_NB < 5 || AUD_NB > 255) begin : g_bad_aud
      $error("ifr_pkt_asm: AUD_NB must cover the level-shift byte");
   end

   logic             snap;
   logic [IDX_W-1:0] idx;

   ifr_seq #(.AVI_TOT(AVI_TOT), .AUD_TOT(AUD_TOT), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
      .avi_set_i(avi_send_i), .avi_cont_i(avi_cont_i),
      .aud_set_i(aud_send_i), .aud_cont_i(aud_cont_i),
      .ready_i(ready_i), .snap_o(snap), .valid_o(valid_o), .last_o(last_o),
      .aud_sel_o(aud_sel_o), .idx_o(idx),
      .avi_pend_o(avi_pend_o), .aud_pend_o(aud_pend_o));

   // shadow copy taken at the frame start that begins a transmission
   logic [AVI_NB*8-1:0] db_q;
   logic [2:0]          cc_q;
   logic [7:0]          ca_q;
   logic [3:0]          lsv_q;
   logic                dmi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         db_q <= '0; cc_q <= '0; ca_q <= '0; lsv_q <= '0; dmi_q <= 1'b0;
      end else if (snap) begin
         db_q <= avi_db_i; cc_q <= aud_cc_i; ca_q <= aud_ca_i;
         lsv_q <= aud_lsv_i; dmi_q <= aud_dmi_i;
      end
   end

   logic [AUD_NB*8-1:0] aud_pb;
   always_comb begin
      aud_pb         = '0;
      aud_pb[7:0]    = {5'b0, cc_q};
      aud_pb[31:24]  = ca_q;
      aud_pb[39:32]  = {dmi_q, lsv_q, 3'b000};
   end

   logic [7:0] avi_cks, aud_cks;
   ifr_cksum #(.NB(AVI_NB + HDR_NB)) u_avi_cks (
      .bytes_i({db_q, 8'(AVI_NB), AVI_VER, AVI_TYPE}), .cks_o(avi_cks));
   ifr_cksum #(.NB(AUD_NB + HDR_NB)) u_aud_cks (
      .bytes_i({aud_pb, 8'(AUD_NB), AUD_VER, AUD_TYPE}), .cks_o(aud_cks));

   logic [7:0] avi_pkt [AVI_TOT];
   logic [7:0] aud_pkt [AUD_TOT];
   assign avi_pkt[0] = AVI_TYPE;
   assign avi_pkt[1] = AVI_VER;
   assign avi_pkt[2] = 8'(AVI_NB);
   assign avi_pkt[3] = avi_cks;
   assign aud_pkt[0] = AUD_TYPE;
   assign aud_pkt[1] = AUD_VER;
   assign aud_pkt[2] = 8'(AUD_NB);
   assign aud_pkt[3] = aud_cks;
   for (genvar g = 0; g < AVI_NB; g++) begin : g_avi_body
      assign avi_pkt[g+4] = db_q[g*8 +: 8];
   end
   for (genvar g = 0; g < AUD_NB; g++) begin : g_aud_body
      assign aud_pkt[g+4] = aud_pb[g*8 +: 8];
   end

   always_comb begin
      byte_o = 8'h00;
      for (int i = 0; i < AVI_TOT; i++)
         if (valid_o && !aud_sel_o && idx == IDX_W'(i)) byte_o = avi_pkt[i];
      for (int i = 0; i < AUD_TOT; i++)
         if (aud_sel_o && idx == IDX_W'(i)) byte_o = aud_pkt[i];
   end

   always_comb begin
      avi_words_o                      = '0;
      avi_words_o[7:0]                 = avi_cks;
      avi_words_o[8 +: AVI_NB*8]       = db_q;
      avi_words_o[AVI_NW*32-8 +: 8]    = AVI_VER;
   end
   assign aud_words_o = {16'h0000, dmi_q, lsv_q, 3'b000, ca_q, 21'h0, cc_q, aud_cks};

   logic [7:0] avi_sum, aud_sum;
   always_comb begin
      avi_sum = 8'h00;
      aud_sum = 8'h00;
      for (int i = 0; i < AVI_TOT; i++) avi_sum = avi_sum + avi_pkt[i];
      for (int i = 0; i < AUD_TOT; i++) aud_sum = aud_sum + aud_pkt[i];
   end

   // R2: every packet sums to zero modulo 256
   p_sum_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (avi_sum == 8'h00 && aud_sum == 8'h00));

   // R10: byte held under backpressure
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(byte_o)));

   // R1: a transmission opens with a type byte
   p_first_type_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> (byte_o == AVI_TYPE || byte_o == AUD_TYPE));
endmodule

// File: tb/ifr_pkt_asm_tb.sv
module ifr_pkt_asm_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frame_start_i = 1'b0;
   logic [103:0] avi_db_i = '0;
   logic [2:0]   aud_cc_i = '0;
   logic [7:0]   aud_ca_i = '0;
   logic [3:0]   aud_lsv_i = '0;
   logic         aud_dmi_i = 1'b0;
   logic         avi_send_i = 1'b0, avi_cont_i = 1'b0;
   logic         aud_send_i = 1'b0, aud_cont_i = 1'b0;
   logic         ready_i = 1'b1;
   logic [7:0]   byte_o;
   logic         valid_o, last_o, aud_sel_o, avi_pend_o, aud_pend_o;
   logic [127:0] avi_words_o;
   logic [63:0]  aud_words_o;

   int n_chk = 0, n_bad = 0;
   logic [7:0] got_q[$];
   logic [7:0] exp_q[$];
   logic       stall_prev = 1'b0;
   logic [7:0] stall_byte = 8'h00;

   always #5 clk = ~clk;

   ifr_pkt_asm dut_i (
      .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
      .avi_db_i(avi_db_i), .aud_cc_i(aud_cc_i), .aud_ca_i(aud_ca_i),
      .aud_lsv_i(aud_lsv_i), .aud_dmi_i(aud_dmi_i),
      .avi_send_i(avi_send_i), .avi_cont_i(avi_cont_i),
      .aud_send_i(aud_send_i), .aud_cont_i(aud_cont_i),
      .ready_i(ready_i), .byte_o(byte_o), .valid_o(valid_o), .last_o(last_o),
      .aud_sel_o(aud_sel_o), .avi_pend_o(avi_pend_o), .aud_pend_o(aud_pend_o),
      .avi_words_o(avi_words_o), .aud_words_o(aud_words_o));

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // collector and backpressure monitor (R10)
   always @(negedge clk) begin
      if (rst_n) begin
         if (stall_prev) check(valid_o && byte_o == stall_byte, "R10 hold", {valid_o, byte_o}, {1'b1, stall_byte});
         if (valid_o && ready_i) got_q.push_back(byte_o);
         stall_prev = valid_o && !ready_i;
         stall_byte = byte_o;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse_frame();
      frame_start_i = 1'b1; cyc(1); frame_start_i = 1'b0;
   endtask

   task automatic arm(input bit avi, input bit aud);
      avi_send_i = avi; aud_send_i = aud; cyc(1);
      avi_send_i = 1'b0; aud_send_i = 1'b0;
   endtask

   function automatic logic [7:0] avi_ck(input logic [103:0] db);
      logic [7:0] s = 8'h82 + 8'h02 + 8'h0D;
      for (int i = 0; i < 13; i++) s = s + db[i*8 +: 8];
      return 8'h00 - s;
   endfunction

   function automatic logic [7:0] aud_ck(input logic [2:0] cc, input logic [7:0] ca,
                                         input logic [3:0] lsv, input logic dmi);
      logic [7:0] s = 8'h84 + 8'h01 + 8'h0A + {5'b0, cc} + ca + {dmi, lsv, 3'b0};
      return 8'h00 - s;
   endfunction

   task automatic push_avi(input logic [103:0] db);
      exp_q.push_back(8'h82); exp_q.push_back(8'h02); exp_q.push_back(8'h0D);
      exp_q.push_back(avi_ck(db));
      for (int i = 0; i < 13; i++) exp_q.push_back(db[i*8 +: 8]);
   endtask

   task automatic push_aud(input logic [2:0] cc, input logic [7:0] ca,
                           input logic [3:0] lsv, input logic dmi);
      exp_q.push_back(8'h84); exp_q.push_back(8'h01); exp_q.push_back(8'h0A);
      exp_q.push_back(aud_ck(cc, ca, lsv, dmi));
      exp_q.push_back({5'b0, cc}); exp_q.push_back(8'h00); exp_q.push_back(8'h00);
      exp_q.push_back(ca); exp_q.push_back({dmi, lsv, 3'b0});
      for (int i = 0; i < 5; i++) exp_q.push_back(8'h00);
   endtask

   task automatic cmp_stream(input string req);
      check(got_q.size() == exp_q.size(), {req, " length"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
      got_q.delete(); exp_q.delete();
   endtask

   function automatic logic [127:0] avi_w(input logic [103:0] db);
      return {8'h02, 8'h00, db, avi_ck(db)};
   endfunction

   function automatic logic [63:0] aud_w(input logic [2:0] cc, input logic [7:0] ca,
                                         input logic [3:0] lsv, input logic dmi);
      return {16'h0, dmi, lsv, 3'b0, ca, 21'h0, cc, aud_ck(cc, ca, lsv, dmi)};
   endfunction

   task automatic t_reset();
      @(negedge clk);
      check(!valid_o, "R12 valid", valid_o, 0);
      check(!avi_pend_o && !aud_pend_o, "R12 pend", {avi_pend_o, aud_pend_o}, 0);
   endtask

   task automatic t_avi_once();
      logic [103:0] db = 104'hF1_E2_D3_C4_B5_A6_97_88_79_6A_5B_4C_3D;
      avi_db_i = db; avi_cont_i = 1'b0;
      arm(1'b1, 1'b0);
      check(avi_pend_o, "R7 pend set", avi_pend_o, 1);
      cyc(6);
      check(got_q.size() == 0, "R7 no frame no bytes", got_q.size(), 0);
      pulse_frame(); cyc(30);
      push_avi(db); cmp_stream("R1 R2 avi stream");
      check(avi_words_o == avi_w(db), "R3 avi words", avi_words_o, avi_w(db));
      check(!avi_pend_o, "R8 one-shot cleared", avi_pend_o, 0);
      pulse_frame(); cyc(30);
      check(got_q.size() == 0, "R8 no resend", got_q.size(), 0);
      got_q.delete();
   endtask

   task automatic t_audio();
      aud_cc_i = 3'd5; aud_ca_i = 8'hF3; aud_lsv_i = 4'hB; aud_dmi_i = 1'b1;
      arm(1'b0, 1'b1);
      pulse_frame(); cyc(30);
      push_aud(3'd5, 8'hF3, 4'hB, 1'b1); cmp_stream("R5 R2 audio stream");
      check(aud_words_o == aud_w(3'd5, 8'hF3, 4'hB, 1'b1), "R4 audio words",
            aud_words_o, aud_w(3'd5, 8'hF3, 4'hB, 1'b1));
      // all-zero audio body
      aud_cc_i = 3'd0; aud_ca_i = 8'h00; aud_lsv_i = 4'h0; aud_dmi_i = 1'b0;
      arm(1'b0, 1'b1);
      pulse_frame(); cyc(30);
      push_aud(3'd0, 8'h00, 4'h0, 1'b0); cmp_stream("R5 R2 zero audio");
      check(aud_words_o == aud_w(3'd0, 8'h00, 4'h0, 1'b0), "R4 zero words",
            aud_words_o, aud_w(3'd0, 8'h00, 4'h0, 1'b0));
   endtask

   task automatic t_both_repeat();
      logic [103:0] db0 = 104'h01_02_03_04_05_06_07_08_09_0A_0B_0C_FF;
      logic [103:0] db1 = 104'h55_AA_55_AA_55_AA_55_AA_55_AA_55_AA_80;
      avi_db_i = db0; aud_cc_i = 3'd1; aud_ca_i = 8'h13; aud_lsv_i = 4'h3; aud_dmi_i = 1'b0;
      avi_cont_i = 1'b1; aud_cont_i = 1'b1;
      arm(1'b1, 1'b1);
      pulse_frame(); cyc(4);
      avi_db_i = db1; aud_cc_i = 3'd7; aud_ca_i = 8'hFE; aud_lsv_i = 4'hF; aud_dmi_i = 1'b1;
      pulse_frame();          // arrives mid-packet: must be dropped (R11)
      cyc(4);
      check(avi_words_o == avi_w(db0), "R9 words hold", avi_words_o, avi_w(db0));
      cyc(50);
      push_avi(db0); push_aud(3'd1, 8'h13, 4'h3, 1'b0);
      cmp_stream("R6 R9 R11 frame one");
      check(avi_pend_o && aud_pend_o, "R8 repeat armed", {avi_pend_o, aud_pend_o}, 2'b11);
      pulse_frame(); cyc(50);
      push_avi(db1); push_aud(3'd7, 8'hFE, 4'hF, 1'b1);
      cmp_stream("R8 R9 frame two");
      check(avi_words_o == avi_w(db1), "R9 words new", avi_words_o, avi_w(db1));
      avi_cont_i = 1'b0; aud_cont_i = 1'b0;
      pulse_frame(); cyc(50);
      got_q.delete();
      check(!avi_pend_o && !aud_pend_o, "R8 disarm", {avi_pend_o, aud_pend_o}, 0);
   endtask

   task automatic t_backpressure();
      logic [103:0] db = 104'h9C_8B_7A_69_58_47_36_25_14_03_F2_E1_D0;
      avi_db_i = db; aud_cc_i = 3'd2; aud_ca_i = 8'h0B; aud_lsv_i = 4'h6; aud_dmi_i = 1'b1;
      arm(1'b1, 1'b1);
      pulse_frame();
      for (int c = 0; c < 150; c++) begin
         ready_i = (c % 3) != 0;
         cyc(1);
      end
      ready_i = 1'b1; cyc(5);
      push_avi(db); push_aud(3'd2, 8'h0B, 4'h6, 1'b1);
      cmp_stream("R10 stalled stream");
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      t_reset();
      cyc(2);
      t_avi_once();
      t_audio();
      t_both_repeat();
      t_backpressure();
      finish_run();
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end
endmodule